// File: doc/BRIEF.md
# Issue Queue Occupancy Controller

This block keeps the books for a shared out-of-order issue queue. Every instruction it holds carries a thread number and a 16-bit sequence number. The block counts how many queue entries are in use, both in total and per thread. It raises full flags, and it offers instructions that are ready to a downstream selector. An instruction is ready once it is allowed to leave: a speculative instruction is ready as soon as it is inserted, and a non-speculative one is ready only after a release command names its sequence number.

An entry stops counting against the queue at a time that depends on its class:

- An ordinary instruction is released when its issue is reported.
- A memory instruction stays counted until a separate completion notice arrives.
- Squashed instructions are released at once when the squash reaches them.

A squash removes the work of one thread whose sequence number is above a boundary. A commit retires list storage up to and including a sequence number. Each thread's entry limit is set in one of two ways: the total divided by the number of active threads, or a configured percentage of the total.

The insert port and the ready port are valid/ready streams. An insert is taken on a clock edge where `ins_valid` and `ins_ready` are both high. `ins_ready` depends on the thread offered, so a source must hold its request stable while it waits. On the ready port, an offer that is not accepted keeps the same instruction on `rdy_tid`/`rdy_seq` until `rdy_ready` is high. The one exception is a squash, commit or issue notice that removes that instruction. All other pins are plain single-cycle commands or level outputs.

Top module: `iq_occupancy_ctrl`

## Requirements
- R1: After reset, `free_cnt` equals DEPTH, every thread count is 0, `full` and every `thr_full` bit are 0, and `rdy_valid` is 0.
- R2: An accepted insert lowers `free_cnt` by one and raises the inserting thread's count by one, visible the cycle after the accepting edge. `ins_ready` is 0 whenever `full` is 1, so no insert is ever taken with zero free entries.
- R3: An issue notice (`iss_valid`, thread, sequence) for a live, unissued, non-memory entry returns its slot: `free_cnt` +1 and the thread count −1 on the next cycle.
- R4: An issue notice for a memory entry (`ins_mem`=1) leaves the counts unchanged. A later completion notice (`done_*`) for it returns the slot.
- R5: A non-speculative insert (`ins_nonspec`=1) is counted but never offered on the ready port. A release command (`sched_*`) with its thread and sequence makes it offered from the next cycle.
- R6: A speculative insert is offered on `rdy_valid`/`rdy_tid`/`rdy_seq` from the cycle after insertion. The offer stays put while `rdy_ready` is 0, and a handshake withdraws it. Among several ready entries the offer goes to the lowest storage slot.
- R7: A squash (`sq_*`) marks every live, not-yet-squashed entry of that thread whose sequence is unsigned-greater than `sq_seq`. Of those, unissued entries and issued-but-uncompleted memory entries return their slots on the next cycle. Entries at or below the boundary, and other threads' entries, are untouched.
- R8: A squashed entry counts as issued and committable. It leaves the ready port, and later issue or completion notices naming it change no count.
- R9: A commit (`cmt_*`) removes from storage every entry of that thread with sequence unsigned ≤ `cmt_seq`. Counts do not change. A removed entry leaves the ready port, and notices naming it afterwards change no count.
- R10: When a squash and a commit arrive in the same cycle, the squash is applied and the commit is dropped.
- R11: With `cfg_mode`=0 (partitioned), the per-thread limit is DEPTH / `cfg_active`, where `cfg_active` is clamped to the range 1..THREADS. `thr_full[t]` is 1 when thread t's count reaches the limit, and `ins_ready` is then 0 for that thread.
- R12: With `cfg_mode`=1 (threshold), the per-thread limit is DEPTH·`cfg_pct`/100 (rounded down, `cfg_pct` capped at 100), applied the same way.
- R13: In every cycle `free_cnt` plus the sum of all thread counts equals DEPTH, and `full` is 1 exactly when `free_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Limit mode: 0 partitioned, 1 threshold |
| cfg_active | input | ACT_W | Active thread count for partitioned mode |
| cfg_pct | input | 7 | Threshold percentage |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_tid | input | TID_W | Inserting thread |
| ins_seq | input | SEQ_W | Sequence number of the insert |
| ins_mem | input | 1 | Insert is a memory instruction |
| ins_nonspec | input | 1 | Insert is non-speculative (held) |
| sched_valid | input | 1 | Release a held instruction |
| sched_tid | input | TID_W | Thread of the release |
| sched_seq | input | SEQ_W | Sequence number to release |
| iss_valid | input | 1 | Issue notice |
| iss_tid | input | TID_W | Thread of the issued instruction |
| iss_seq | input | SEQ_W | Sequence number issued |
| done_valid | input | 1 | Memory completion notice |
| done_tid | input | TID_W | Thread of the completion |
| done_seq | input | SEQ_W | Sequence number completed |
| cmt_valid | input | 1 | Commit command |
| cmt_tid | input | TID_W | Thread to commit |
| cmt_seq | input | SEQ_W | Commit up to and including this sequence |
| sq_valid | input | 1 | Squash command |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Squash everything above this sequence |
| rdy_valid | output | 1 | A ready instruction is offered |
| rdy_ready | input | 1 | Selector accepts the offer |
| rdy_tid | output | TID_W | Thread of the offered instruction |
| rdy_seq | output | SEQ_W | Sequence of the offered instruction |
| free_cnt | output | CNT_W | Free queue entries |
| thr_cnt | output | THREADS·CNT_W | Per-thread entry counts, thread 0 in the low bits |
| full | output | 1 | No free entries |
| thr_full | output | THREADS | Per-thread limit reached |

## Verification
Every count and flag is registered. The effect of an insert, issue, completion, squash or commit shows on `free_cnt`, `thr_cnt`, `full` and `thr_full` exactly one cycle after the edge that samples the command. The ready offer also appears one cycle after the insert or release edge, and a handshake removes it one cycle after the accepting edge. `ins_ready` is combinational and can be read in the same cycle the request is driven. The bench drives every command on a falling edge, lets one rising edge pass, and samples on the next falling edge. Each result is therefore read in the first cycle it is due, and never at an edge.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int SEQ_W_DEF = 16;

  typedef struct packed {
    logic vld;   // slot holds an instruction on the thread list
    logic held;  // non-speculative, waiting for release
    logic pend;  // ready, not yet handed to the selector
    logic iss;   // issued (or squashed)
    logic cpl;   // memory op completed
    logic sqd;   // squashed inside the queue
    logic mem;   // memory instruction
  } iq_flags_t;
endpackage

// File: rtl/iq_limit_calc.sv
module iq_limit_calc #(
  parameter int DEPTH   = 8,
  parameter int THREADS = 2,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ACT_W  = $clog2(THREADS + 1)
) (
  input  logic             cfg_mode,
  input  logic [ACT_W-1:0] cfg_active,
  input  logic [6:0]       cfg_pct,
  output logic [CNT_W-1:0] limit
);
  int act_n, pct_n, part_n, thr_n;

  always_comb begin
    act_n = int'(cfg_active);
    if (act_n < 1) act_n = 1;
    if (act_n > THREADS) act_n = THREADS;
    pct_n = int'(cfg_pct);
    if (pct_n > 100) pct_n = 100;
    part_n = DEPTH / act_n;
    thr_n  = (DEPTH * pct_n) / 100;
    limit  = cfg_mode ? CNT_W'(thr_n) : CNT_W'(part_n);
  end
endmodule

// File: rtl/iq_push_pick.sv
module iq_push_pick #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/iq_slot_store.sv
module iq_slot_store
  import iq_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_fire,
  input  logic [TID_W-1:0]         ins_tid,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic                     ins_mem,
  input  logic                     ins_nonspec,
  input  logic                     sched_valid,
  input  logic [TID_W-1:0]         sched_tid,
  input  logic [SEQ_W-1:0]         sched_seq,
  input  logic                     iss_valid,
  input  logic [TID_W-1:0]         iss_tid,
  input  logic [SEQ_W-1:0]         iss_seq,
  input  logic                     done_valid,
  input  logic [TID_W-1:0]         done_tid,
  input  logic [SEQ_W-1:0]         done_seq,
  input  logic                     cmt_valid,
  input  logic [TID_W-1:0]         cmt_tid,
  input  logic [SEQ_W-1:0]         cmt_seq,
  input  logic                     sq_valid,
  input  logic [TID_W-1:0]         sq_tid,
  input  logic [SEQ_W-1:0]         sq_seq,
  input  logic                     push_fire,
  input  logic [IDX_W-1:0]         push_idx,
  output logic [SLOTS-1:0]         pend_vec,
  output logic [SLOTS-1:0]         rel_vec,
  output logic [SLOTS*TID_W-1:0]   tid_flat,
  output logic [SLOTS*SEQ_W-1:0]   seq_flat,
  output logic                     has_space
);
  logic [SLOTS-1:0] empty_vec;
  logic [IDX_W-1:0] alloc_idx;

  always_comb begin
    alloc_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (empty_vec[i]) alloc_idx = IDX_W'(i);
    end
  end
  assign has_space = |empty_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    iq_flags_t        fl;
    logic [TID_W-1:0] tid_q;
    logic [SEQ_W-1:0] seq_q;
    logic own_sq, own_sched, own_iss, own_done, own_cmt, take;

    assign take      = ins_fire && (alloc_idx == IDX_W'(i));
    assign own_sq    = sq_valid && fl.vld && !fl.sqd && (tid_q == sq_tid) && (seq_q > sq_seq);
    assign own_sched = sched_valid && fl.vld && fl.held && !fl.sqd &&
                       (tid_q == sched_tid) && (seq_q == sched_seq);
    assign own_iss   = iss_valid && fl.vld && !fl.held && !fl.iss && !fl.sqd && !own_sq &&
                       (tid_q == iss_tid) && (seq_q == iss_seq);
    assign own_done  = done_valid && fl.vld && fl.mem && fl.iss && !fl.cpl && !fl.sqd && !own_sq &&
                       (tid_q == done_tid) && (seq_q == done_seq);
    assign own_cmt   = cmt_valid && !sq_valid && fl.vld && (tid_q == cmt_tid) && (seq_q <= cmt_seq);

    assign rel_vec[i]   = (own_sq && (!fl.iss || (fl.mem && !fl.cpl))) ||
                          (own_iss && !fl.mem) || own_done;
    assign pend_vec[i]  = fl.vld && fl.pend && !fl.sqd;
    assign empty_vec[i] = !fl.vld;
    assign tid_flat[i*TID_W +: TID_W] = tid_q;
    assign seq_flat[i*SEQ_W +: SEQ_W] = seq_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fl    <= '0;
        tid_q <= '0;
        seq_q <= '0;
      end else if (take) begin
        fl      <= '0;
        fl.vld  <= 1'b1;
        fl.held <= ins_nonspec;
        fl.pend <= !ins_nonspec;
        fl.mem  <= ins_mem;
        tid_q   <= ins_tid;
        seq_q   <= ins_seq;
      end else if (own_cmt) begin
        fl <= '0;
      end else begin
        if (own_sched) begin
          fl.held <= 1'b0;
          fl.pend <= 1'b1;
        end
        if (own_iss) begin
          fl.iss  <= 1'b1;
          fl.pend <= 1'b0;
        end
        if (own_done) fl.cpl <= 1'b1;
        if (push_fire && (push_idx == IDX_W'(i))) fl.pend <= 1'b0;
        if (own_sq) begin
          fl.sqd  <= 1'b1;
          fl.iss  <= 1'b1;   // drains as issued and committable
          fl.held <= 1'b0;
          fl.pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/iq_occupancy_ctrl.sv
module iq_occupancy_ctrl
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int THREADS = 2,
  parameter int SLOTS   = 2 * DEPTH,
  parameter int SEQ_W   = SEQ_W_DEF,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ACT_W  = $clog2(THREADS + 1),
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_mode,
  input  logic [ACT_W-1:0]         cfg_active,
  input  logic [6:0]               cfg_pct,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [TID_W-1:0]         ins_tid,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic                     ins_mem,
  input  logic                     ins_nonspec,
  input  logic                     sched_valid,
  input  logic [TID_W-1:0]         sched_tid,
  input  logic [SEQ_W-1:0]         sched_seq,
  input  logic                     iss_valid,
  input  logic [TID_W-1:0]         iss_tid,
  input  logic [SEQ_W-1:0]         iss_seq,
  input  logic                     done_valid,
  input  logic [TID_W-1:0]         done_tid,
  input  logic [SEQ_W-1:0]         done_seq,
  input  logic                     cmt_valid,
  input  logic [TID_W-1:0]         cmt_tid,
  input  logic [SEQ_W-1:0]         cmt_seq,
  input  logic                     sq_valid,
  input  logic [TID_W-1:0]         sq_tid,
  input  logic [SEQ_W-1:0]         sq_seq,
  output logic                     rdy_valid,
  input  logic                     rdy_ready,
  output logic [TID_W-1:0]         rdy_tid,
  output logic [SEQ_W-1:0]         rdy_seq,
  output logic [CNT_W-1:0]         free_cnt,
  output logic [THREADS*CNT_W-1:0] thr_cnt,
  output logic                     full,
  output logic [THREADS-1:0]       thr_full
);
  logic                     ins_fire, push_fire, has_space, pick_any;
  logic [SLOTS-1:0]         pend_vec, rel_vec;
  logic [SLOTS*TID_W-1:0]   tid_flat;
  logic [SLOTS*SEQ_W-1:0]   seq_flat;
  logic [IDX_W-1:0]         pick_idx, sel_idx, lock_idx_q;
  logic                     lock_q;
  logic [CNT_W-1:0]         limit, free_q;
  int                       rel_total;
  int                       rel_thr [THREADS];

  iq_limit_calc #(.DEPTH(DEPTH), .THREADS(THREADS)) u_limit (
    .cfg_mode(cfg_mode), .cfg_active(cfg_active), .cfg_pct(cfg_pct), .limit(limit)
  );

  iq_slot_store #(.SLOTS(SLOTS), .THREADS(THREADS), .SEQ_W(SEQ_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins_fire(ins_fire), .ins_tid(ins_tid), .ins_seq(ins_seq),
    .ins_mem(ins_mem), .ins_nonspec(ins_nonspec),
    .sched_valid(sched_valid), .sched_tid(sched_tid), .sched_seq(sched_seq),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_seq(iss_seq),
    .done_valid(done_valid), .done_tid(done_tid), .done_seq(done_seq),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .push_fire(push_fire), .push_idx(sel_idx),
    .pend_vec(pend_vec), .rel_vec(rel_vec),
    .tid_flat(tid_flat), .seq_flat(seq_flat), .has_space(has_space)
  );

  iq_push_pick #(.N(SLOTS)) u_pick (.req(pend_vec), .any(pick_any), .idx(pick_idx));

  // keep an un-accepted offer pinned to the same slot
  assign sel_idx   = (lock_q && pend_vec[lock_idx_q]) ? lock_idx_q : pick_idx;
  assign rdy_valid = pick_any;
  assign rdy_tid   = tid_flat[sel_idx*TID_W +: TID_W];
  assign rdy_seq   = seq_flat[sel_idx*SEQ_W +: SEQ_W];
  assign push_fire = rdy_valid && rdy_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= rdy_valid && !rdy_ready;
      lock_idx_q <= sel_idx;
    end
  end

  assign full      = (free_q == '0);
  assign free_cnt  = free_q;
  assign ins_ready = !full && !thr_full[ins_tid] && has_space;
  assign ins_fire  = ins_valid && ins_ready;

  always_comb begin
    rel_total = 0;
    for (int t = 0; t < THREADS; t++) rel_thr[t] = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rel_vec[i]) begin
        rel_total = rel_total + 1;
        for (int t = 0; t < THREADS; t++) begin
          if (tid_flat[i*TID_W +: TID_W] == TID_W'(t)) rel_thr[t] = rel_thr[t] + 1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= CNT_W'(DEPTH);
    else        free_q <= CNT_W'(int'(free_q) + rel_total - int'(ins_fire));
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] cnt_q;
    logic             add;
    assign add = ins_fire && (ins_tid == TID_W'(t));
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= CNT_W'(int'(cnt_q) + int'(add) - rel_thr[t]);
    end
    assign thr_cnt[t*CNT_W +: CNT_W] = cnt_q;
    assign thr_full[t] = (cnt_q >= limit);
  end
endmodule

// File: rtl/iq_occupancy_ctrl_chk.sv
module iq_occupancy_ctrl_chk #(
  parameter int DEPTH   = 8,
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ins_valid,
  input logic                     ins_ready,
  input logic [TID_W-1:0]         ins_tid,
  input logic                     iss_valid,
  input logic                     cmt_valid,
  input logic                     sq_valid,
  input logic                     rdy_valid,
  input logic                     rdy_ready,
  input logic [SEQ_W-1:0]         rdy_seq,
  input logic [CNT_W-1:0]         free_cnt,
  input logic [THREADS*CNT_W-1:0] thr_cnt,
  input logic                     full,
  input logic [THREADS-1:0]       thr_full
);
  int used_sum;
  always_comb begin
    used_sum = 0;
    for (int t = 0; t < THREADS; t++) used_sum = used_sum + int'(thr_cnt[t*CNT_W +: CNT_W]);
  end

  assert_count_sum_R13: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) + used_sum == DEPTH);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |-> !full);

  assert_thread_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |-> !thr_full[ins_tid]);

  assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_valid && !rdy_ready && !sq_valid && !cmt_valid && !iss_valid)
      |=> (rdy_valid && $stable(rdy_seq)));
endmodule

bind iq_occupancy_ctrl iq_occupancy_ctrl_chk #(.DEPTH(DEPTH), .THREADS(THREADS), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tid(ins_tid),
  .iss_valid(iss_valid), .cmt_valid(cmt_valid), .sq_valid(sq_valid),
  .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_seq(rdy_seq),
  .free_cnt(free_cnt), .thr_cnt(thr_cnt), .full(full), .thr_full(thr_full)
);

// File: tb/iq_occupancy_ctrl_tb.sv
`timescale 1ns/1ps
module iq_occupancy_ctrl_tb;
  localparam int DEPTH = 8, THREADS = 2, SEQ_W = 16;
  localparam int TID_W = 1, CNT_W = 4, ACT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mode = 1'b0;
  logic [ACT_W-1:0] cfg_active = 2'd1;
  logic [6:0] cfg_pct = 7'd100;
  logic ins_valid = 0, ins_mem = 0, ins_nonspec = 0, ins_ready;
  logic [TID_W-1:0] ins_tid = '0, sched_tid = '0, iss_tid = '0, done_tid = '0, cmt_tid = '0, sq_tid = '0, rdy_tid;
  logic [SEQ_W-1:0] ins_seq = '0, sched_seq = '0, iss_seq = '0, done_seq = '0, cmt_seq = '0, sq_seq = '0, rdy_seq;
  logic sched_valid = 0, iss_valid = 0, done_valid = 0, cmt_valid = 0, sq_valid = 0;
  logic rdy_valid, rdy_ready = 1'b1, full;
  logic [CNT_W-1:0] free_cnt;
  logic [THREADS*CNT_W-1:0] thr_cnt;
  logic [THREADS-1:0] thr_full;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iq_occupancy_ctrl #(.DEPTH(DEPTH), .THREADS(THREADS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_active(cfg_active), .cfg_pct(cfg_pct),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tid(ins_tid), .ins_seq(ins_seq),
    .ins_mem(ins_mem), .ins_nonspec(ins_nonspec),
    .sched_valid(sched_valid), .sched_tid(sched_tid), .sched_seq(sched_seq),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_seq(iss_seq),
    .done_valid(done_valid), .done_tid(done_tid), .done_seq(done_seq),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_tid(rdy_tid), .rdy_seq(rdy_seq),
    .free_cnt(free_cnt), .thr_cnt(thr_cnt), .full(full), .thr_full(thr_full)
  );

  function automatic int tcnt(int t);
    return int'(thr_cnt[t*CNT_W +: CNT_W]);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(int tid, int seq, bit mem, bit ns);
    ins_valid = 1; ins_tid = TID_W'(tid); ins_seq = SEQ_W'(seq); ins_mem = mem; ins_nonspec = ns;
    step();
    ins_valid = 0; ins_mem = 0; ins_nonspec = 0;
  endtask

  task automatic issue(int tid, int seq);
    iss_valid = 1; iss_tid = TID_W'(tid); iss_seq = SEQ_W'(seq);
    step();
    iss_valid = 0;
  endtask

  task automatic complete(int tid, int seq);
    done_valid = 1; done_tid = TID_W'(tid); done_seq = SEQ_W'(seq);
    step();
    done_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 free", int'(free_cnt), DEPTH);
    check("R1 thr0", tcnt(0), 0);
    check("R1 thr1", tcnt(1), 0);
    check("R1 full", int'(full), 0);
    check("R1 thr_full", int'(thr_full), 0);
    check("R1 rdy_valid", int'(rdy_valid), 0);
  endtask

  task automatic t_push_and_issue();
    do_reset();
    rdy_ready = 0;
    put(0, 10, 0, 0);
    check("R2 free after insert", int'(free_cnt), 7);
    check("R2 thr0 after insert", tcnt(0), 1);
    check("R6 offered", int'(rdy_valid), 1);
    check("R6 offered seq", int'(rdy_seq), 10);
    check("R6 offered tid", int'(rdy_tid), 0);
    step();
    check("R6 held", int'(rdy_valid), 1);
    check("R6 held seq", int'(rdy_seq), 10);
    rdy_ready = 1;
    step();
    check("R6 withdrawn after handshake", int'(rdy_valid), 0);
    issue(0, 10);
    check("R3 free after issue", int'(free_cnt), 8);
    check("R3 thr0 after issue", tcnt(0), 0);
  endtask

  task automatic t_memory();
    do_reset();
    rdy_ready = 1;
    put(1, 20, 1, 0);
    step();
    issue(1, 20);
    check("R4 mem issue keeps free", int'(free_cnt), 7);
    check("R4 mem issue keeps thr1", tcnt(1), 1);
    complete(1, 20);
    check("R4 completion frees", int'(free_cnt), 8);
    check("R4 completion thr1", tcnt(1), 0);
  endtask

  task automatic t_nonspec();
    do_reset();
    rdy_ready = 1;
    put(0, 30, 0, 1);
    check("R5 held not offered", int'(rdy_valid), 0);
    check("R5 held counted", int'(free_cnt), 7);
    step();
    check("R5 still held", int'(rdy_valid), 0);
    sched_valid = 1; sched_tid = 0; sched_seq = 30;
    step();
    sched_valid = 0;
    check("R5 released offered", int'(rdy_valid), 1);
    check("R5 released seq", int'(rdy_seq), 30);
    step();
    issue(0, 30);
    check("R5 free after issue", int'(free_cnt), 8);
  endtask

  task automatic t_squash();
    do_reset();
    rdy_ready = 0;
    put(0, 40, 0, 0);
    put(0, 41, 0, 0);
    put(0, 42, 0, 0);
    put(1, 43, 0, 0);
    put(0, 44, 1, 0);
    issue(0, 40);
    issue(0, 44);
    check("R7 pre free", int'(free_cnt), 4);
    check("R7 pre thr0", tcnt(0), 3);
    sq_valid = 1; sq_tid = 0; sq_seq = 41;
    step();
    sq_valid = 0;
    check("R7 squash free", int'(free_cnt), 6);
    check("R7 squash thr0", tcnt(0), 1);
    check("R7 other thread kept", tcnt(1), 1);
    issue(0, 42);
    check("R8 issue of squashed ignored", int'(free_cnt), 6);
    complete(0, 44);
    check("R8 completion of squashed ignored", int'(free_cnt), 6);
    issue(0, 41);
    check("R7 boundary entry still live", int'(free_cnt), 7);
    check("R8 squashed entry not offered", int'(rdy_seq), 43);
    rdy_ready = 1;
  endtask

  task automatic t_commit();
    do_reset();
    rdy_ready = 0;
    put(0, 50, 0, 0);
    sq_valid = 1; sq_tid = 1; sq_seq = 0;
    cmt_valid = 1; cmt_tid = 0; cmt_seq = 60;
    step();
    sq_valid = 0; cmt_valid = 0;
    check("R10 commit dropped under squash", int'(rdy_valid), 1);
    check("R10 offer seq", int'(rdy_seq), 50);
    cmt_valid = 1; cmt_tid = 0; cmt_seq = 60;
    step();
    cmt_valid = 0;
    check("R9 committed entry leaves port", int'(rdy_valid), 0);
    check("R9 counts unchanged", int'(free_cnt), 7);
    issue(0, 50);
    check("R9 issue of removed ignored", int'(free_cnt), 7);
    check("R9 thr0 unchanged", tcnt(0), 1);
    rdy_ready = 1;
  endtask

  task automatic t_full();
    do_reset();
    rdy_ready = 1;
    for (int k = 1; k <= DEPTH; k++) put(0, k, 0, 0);
    check("R13 free zero", int'(free_cnt), 0);
    check("R13 full flag", int'(full), 1);
    ins_valid = 1; ins_tid = 1; ins_seq = 99;
    #1;
    check("R2 no accept when full", int'(ins_ready), 0);
    ins_valid = 0;
    issue(0, 1);
    check("R13 full clears", int'(full), 0);
    ins_tid = 1;
    #1;
    check("R2 accept again", int'(ins_ready), 1);
  endtask

  task automatic t_partition();
    cfg_mode = 0; cfg_active = 2;
    do_reset();
    for (int k = 1; k <= 4; k++) put(0, k, 0, 0);
    check("R11 thr0 full", int'(thr_full[0]), 1);
    check("R11 thr1 not full", int'(thr_full[1]), 0);
    ins_tid = 0;
    #1;
    check("R11 thr0 blocked", int'(ins_ready), 0);
    ins_tid = 1;
    #1;
    check("R11 thr1 open", int'(ins_ready), 1);
    cfg_active = 1;
    #1;
    check("R11 one active limit 8", int'(thr_full[0]), 0);
  endtask

  task automatic t_threshold();
    cfg_mode = 1; cfg_pct = 30;
    do_reset();
    put(1, 5, 0, 0);
    check("R12 below limit", int'(thr_full[1]), 0);
    put(1, 6, 0, 0);
    check("R12 limit 2 reached", int'(thr_full[1]), 1);
    check("R12 other thread", int'(thr_full[0]), 0);
    cfg_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_push_and_issue();
    t_memory();
    t_nonspec();
    t_squash();
    t_commit();
    t_full();
    t_partition();
    t_threshold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule